// File: doc/BRIEF.md
# Data Memory Access Unit

This unit carries out the memory-reference instructions of a small 32-bit register-to-register processor. In that processor every arithmetic and logic operation works on registers only, so this unit is the only path between the register file and data memory. Each cycle it can take one instruction: the decoded 6-bit opcode, the base register value, the 16-bit displacement field and, for stores, the source register value. Loads also carry the index of the destination register.

The effective address is the base plus the sign-extended displacement, taken modulo 2^32 as an unsigned value. The unit presents that address to a synchronous, byte-addressed, little-endian data memory. A store drives write data and per-lane byte enables in the same cycle. A load raises a read enable, and the memory answers one clock later. In that later cycle the unit raises a one-cycle completion pulse and passes the read word and the destination index to writeback. Word accesses must be aligned to four bytes. A word access that is not aligned raises an error flag and does not touch memory.

Top module: `mem_access_unit`

## Requirements
- R1: Whenever an instruction is offered, memAddr equals baseVal plus dispImm sign-extended to 32 bits, modulo 2^32.
- R2: A word store (opcode 6'h2B) whose address bits 1:0 are 00 drives memBe = 4'b1111, memWdata = storeVal and memRe = 0.
- R3: A byte store (opcode 6'h28) drives exactly one byte enable, bit memAddr[1:0], with the low byte of storeVal copied onto all four 8-bit lanes of memWdata (lane k is memWdata[8k+7:8k], holding byte address k of the word). It never raises alignErr, whatever the address.
- R4: A word load (opcode 6'h23) whose address bits 1:0 are 00 drives memRe = 1 and memBe = 0. On the next cycle loadDone = 1, loadData equals the memory word, and loadRdIdx equals the rdIdxIn that was offered with the load.
- R5: A word load or word store whose address bits 1:0 are not 00 raises alignErr in the same cycle, drives memBe = 0 and memRe = 0, and produces no loadDone on the next cycle. Memory contents stay unchanged.
- R6: With issueValid low, or with any opcode other than the three above, memBe = 0, memRe = 0 and alignErr = 0, and memory stays unchanged.
- R7: After reset, loadDone is 0 and loadData is 0.
- R8: loadDone is high only in the cycle right after an accepted load, so back-to-back loads give back-to-back pulses. While loadDone is low, loadData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction is offered this cycle |
| opcode | input | 6 | Decoded primary opcode |
| baseVal | input | 32 | Base register value |
| dispImm | input | 16 | Signed displacement field |
| storeVal | input | 32 | Source register value for stores |
| rdIdxIn | input | 5 | Destination register index for loads |
| memAddr | output | 32 | Effective byte address |
| memWdata | output | 32 | Write data, lane-steered |
| memBe | output | 4 | Per-lane write enables |
| memRe | output | 1 | Read request |
| memRdata | input | 32 | Read data, valid one cycle after memRe |
| loadDone | output | 1 | Load result valid this cycle |
| loadData | output | 32 | Loaded word for writeback |
| loadRdIdx | output | 5 | Destination index of the returned load |
| alignErr | output | 1 | Misaligned word access, write suppressed |

## Verification
The hardest outcomes to reach are the ones where the address only lands on the intended word because the addition wraps, or because the displacement is negative. The same holds for the proof that a suppressed misaligned store left memory untouched. The stimulus picks the target address first and a random displacement second, then solves for the base. Wrapped sums and negative offsets therefore turn up in most operations, while every access still lands in the modelled memory. The bench model memory is checked later by loads of the same words, so a stray write from a misaligned or non-memory instruction shows up as a wrong loaded value.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int OPC_W = 6;
  localparam logic [OPC_W-1:0] OPC_LOAD_WORD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE_WORD = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_STORE_BYTE = 6'h28;

  // strobes from control to datapath
  typedef struct packed {
    logic rdEn;
    logic wordWr;
    logic byteWr;
    logic alignErr;
  } lsuStrobe_t;
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int LANE_SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  issueValid,
  input  logic [OPC_W-1:0]      opcode,
  input  logic [LANE_SEL_W-1:0] addrLow,
  output lsuStrobe_t            strobe,
  output logic                  pendingLoad
);
  logic isLoad, isWordStore, isByteStore, misaligned;

  always_comb begin
    isLoad      = issueValid && (opcode == OPC_LOAD_WORD);
    isWordStore = issueValid && (opcode == OPC_STORE_WORD);
    isByteStore = issueValid && (opcode == OPC_STORE_BYTE);
    misaligned  = (addrLow != '0);
    strobe.rdEn     = isLoad && !misaligned;
    strobe.wordWr   = isWordStore && !misaligned;
    strobe.byteWr   = isByteStore;
    strobe.alignErr = (isLoad || isWordStore) && misaligned;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendingLoad <= 1'b0;
    else       pendingLoad <= strobe.rdEn;
  end
endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      baseVal,
  input  logic [IMM_W-1:0]       dispImm,
  input  logic [DATA_W-1:0]      storeVal,
  input  logic [IDX_W-1:0]       rdIdxIn,
  input  logic [DATA_W-1:0]      memRdata,
  input  lsuStrobe_t             strobe,
  input  logic                   pendingLoad,
  output logic [ADDR_W-1:0]      effAddr,
  output logic [DATA_W-1:0]      memWdata,
  output logic [DATA_W/8-1:0]    memBe,
  output logic [DATA_W-1:0]      loadData,
  output logic [IDX_W-1:0]       loadRdIdx
);
  localparam int LANES      = DATA_W / 8;
  localparam int LANE_SEL_W = $clog2(LANES);

  logic [ADDR_W-1:0]     dispExt;
  logic [LANE_SEL_W-1:0] laneSel;
  logic [DATA_W-1:0]     byteRep;

  assign dispExt = {{(ADDR_W-IMM_W){dispImm[IMM_W-1]}}, dispImm};
  assign effAddr = baseVal + dispExt;
  assign laneSel = effAddr[LANE_SEL_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign byteRep[g*8 +: 8] = storeVal[7:0];
    assign memBe[g] = strobe.wordWr ||
                      (strobe.byteWr && (laneSel == LANE_SEL_W'(g)));
  end

  assign memWdata = strobe.byteWr ? byteRep : storeVal;
  assign loadData = pendingLoad ? memRdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN)            loadRdIdx <= '0;
    else if (strobe.rdEn) loadRdIdx <= rdIdxIn;
  end
endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic [5:0]          opcode,
  input  logic [ADDR_W-1:0]   baseVal,
  input  logic [IMM_W-1:0]    dispImm,
  input  logic [DATA_W-1:0]   storeVal,
  input  logic [IDX_W-1:0]    rdIdxIn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W/8-1:0] memBe,
  output logic                memRe,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                loadDone,
  output logic [DATA_W-1:0]   loadData,
  output logic [IDX_W-1:0]    loadRdIdx,
  output logic                alignErr
);
  localparam int LANE_SEL_W = $clog2(DATA_W / 8);

  lsuStrobe_t strobe;
  logic       pendingLoad;

  lsu_ctrl #(.LANE_SEL_W(LANE_SEL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .opcode(opcode),
    .addrLow(memAddr[LANE_SEL_W-1:0]), .strobe(strobe),
    .pendingLoad(pendingLoad)
  );

  lsu_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_W(IMM_W),
                 .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .baseVal(baseVal), .dispImm(dispImm),
    .storeVal(storeVal), .rdIdxIn(rdIdxIn), .memRdata(memRdata),
    .strobe(strobe), .pendingLoad(pendingLoad), .effAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe), .loadData(loadData),
    .loadRdIdx(loadRdIdx)
  );

  assign memRe    = strobe.rdEn;
  assign alignErr = strobe.alignErr;
  assign loadDone = pendingLoad;
endmodule

// File: rtl/mem_access_unit_chk.sv
module mem_access_unit_chk
  import lsu_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        issueValid,
  input logic [5:0]  opcode,
  input logic [31:0] baseVal,
  input logic [15:0] dispImm,
  input logic [31:0] memAddr,
  input logic [3:0]  memBe,
  input logic        memRe,
  input logic        loadDone,
  input logic [31:0] loadData,
  input logic        alignErr
);
  logic isMemOp;
  assign isMemOp = issueValid && (opcode == OPC_LOAD_WORD ||
                   opcode == OPC_STORE_WORD || opcode == OPC_STORE_BYTE);

  assert_full_word_R2: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && opcode == OPC_STORE_WORD && memAddr[1:0] == 2'b00)
      |-> (memBe == 4'hF && !memRe));

  assert_one_lane_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && opcode == OPC_STORE_BYTE)
      |-> ($countones(memBe) == 1 && memBe[memAddr[1:0]] && !alignErr));

  assert_load_returns_R4: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> loadDone);

  assert_err_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> (memBe == 4'h0 && !memRe));

  assert_err_no_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |=> !loadDone);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !isMemOp |-> (memBe == 4'h0 && !memRe && !alignErr));

  assert_done_from_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> $past(memRe));

  assert_data_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !loadDone |-> (loadData == 32'h0));
endmodule

bind mem_access_unit mem_access_unit_chk chk_i (.*);

// File: tb/mem_access_unit_tb_top.sv
module mem_access_unit_tb_top;
  localparam logic [5:0] LW = 6'h23, SW = 6'h2B, SB = 6'h28;
  localparam int WORDS = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [5:0]  opcode = 6'h0;
  logic [31:0] baseVal = '0;
  logic [15:0] dispImm = '0;
  logic [31:0] storeVal = '0;
  logic [4:0]  rdIdxIn = '0;
  logic [31:0] memAddr, memWdata, memRdata, loadData;
  logic [3:0]  memBe;
  logic        memRe, loadDone, alignErr;
  logic [4:0]  loadRdIdx;

  logic [31:0] mem    [WORDS];
  logic [31:0] refMem [WORDS];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mem_access_unit dut_i (.*);

  // memory model: synchronous read, byte-lane writes
  always @(posedge clk) begin
    if (memRe) memRdata <= mem[memAddr[9:2]];
    for (int k = 0; k < 4; k++)
      if (memBe[k]) mem[memAddr[9:2]][k*8 +: 8] <= memWdata[k*8 +: 8];
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sext(logic [15:0] d);
    return {{16{d[15]}}, d};
  endfunction

  function automatic logic [3:0] expBe(logic [5:0] op, logic [31:0] a);
    if (op == SW && a[1:0] == 2'b00) return 4'hF;
    if (op == SB) return 4'b0001 << a[1:0];
    return 4'h0;
  endfunction

  // offer one instruction, check same-cycle outputs, then idle one cycle
  // and check the load return
  task automatic doOp(logic [5:0] op, logic [31:0] ea, logic [15:0] d,
                      logic [31:0] sv, logic [4:0] rd);
    logic [3:0] be;
    logic [31:0] wd;
    logic isWord, mis;
    @(negedge clk);
    issueValid = 1'b1; opcode = op; dispImm = d;
    baseVal = ea - sext(d); storeVal = sv; rdIdxIn = rd;
    isWord = (op == LW || op == SW);
    mis = (ea[1:0] != 2'b00);
    be = expBe(op, ea);
    wd = (op == SB) ? {4{sv[7:0]}} : sv;
    #1;
    check("R1", "memAddr", memAddr, ea);
    check((op == SB) ? "R3" : (isWord && mis) ? "R5" : (op == SW) ? "R2" : (op == LW) ? "R4" : "R6",
          "memBe", {28'h0, memBe}, {28'h0, be});
    check((isWord && mis) ? "R5" : (op == LW) ? "R4" : "R6", "memRe",
          {31'h0, memRe}, {31'h0, op == LW && !mis});
    check((op == SB) ? "R3" : isWord ? "R5" : "R6", "alignErr",
          {31'h0, alignErr}, {31'h0, isWord && mis});
    if (be != 4'h0) begin
      check((op == SB) ? "R3" : "R2", "memWdata", memWdata, wd);
      for (int k = 0; k < 4; k++)
        if (be[k]) refMem[ea[9:2]][k*8 +: 8] = wd[k*8 +: 8];
    end
    @(negedge clk);
    issueValid = 1'b0;
    #1;
    if (op == LW && !mis) begin
      check("R4", "loadDone", {31'h0, loadDone}, 32'h1);
      check("R4", "loadData", loadData, refMem[ea[9:2]]);
      check("R4", "loadRdIdx", {27'h0, loadRdIdx}, {27'h0, rd});
    end else begin
      check((isWord && mis) ? "R5" : "R8", "loadDone", {31'h0, loadDone}, 32'h0);
      check("R8", "loadData idle", loadData, 32'h0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) begin
      mem[i] = i * 32'h01030507 ^ 32'hA5C3_0F00;
      refMem[i] = i * 32'h01030507 ^ 32'hA5C3_0F00;
    end
    repeat (3) @(negedge clk);
    #1;
    check("R7", "loadDone reset", {31'h0, loadDone}, 32'h0);
    check("R7", "loadData reset", loadData, 32'h0);
    @(negedge clk); rstN = 1'b1;

    // directed corners
    doOp(SW, 32'h0000_0010, 16'hFFF0, 32'hDEAD_BEEF, 5'd1);   // R2 negative disp
    doOp(LW, 32'h0000_0010, 16'h7FFF, 32'h0, 5'd9);           // R4 readback
    for (int l = 0; l < 4; l++)                                // R3 every lane
      doOp(SB, 32'h0000_0020 + l, 16'h8000, 32'h1234_5600 + l * 17, 5'd0);
    doOp(LW, 32'h0000_0020, 16'h0004, 32'h0, 5'd31);          // R3 lanes landed
    doOp(SW, 32'h0000_0031, 16'h0001, 32'hFFFF_FFFF, 5'd0);   // R5 store
    doOp(LW, 32'h0000_0032, 16'h0000, 32'h0, 5'd4);           // R5 load
    doOp(LW, 32'h0000_0030, 16'h0000, 32'h0, 5'd5);           // R5 memory intact
    doOp(6'h08, 32'h0000_0040, 16'h0, 32'h5555_5555, 5'd2);   // R6 other opcode
    doOp(6'h20, 32'h0000_0040, 16'h0, 32'h5555_5555, 5'd2);   // R6 other opcode
    doOp(LW, 32'h0000_0040, 16'h0, 32'h0, 5'd6);              // R6 memory intact

    // R6: issueValid low with a store opcode
    @(negedge clk);
    opcode = SW; baseVal = 32'h44; dispImm = 16'h0; storeVal = 32'h0;
    #1;
    check("R6", "memBe invalid", {28'h0, memBe}, 32'h0);
    check("R6", "memRe invalid", {31'h0, memRe}, 32'h0);

    // R8: back-to-back loads
    @(negedge clk);
    issueValid = 1'b1; opcode = LW; baseVal = 32'h50; dispImm = 16'h0; rdIdxIn = 5'd7;
    @(negedge clk);
    baseVal = 32'h54; rdIdxIn = 5'd8;
    #1;
    check("R8", "loadDone b2b first", {31'h0, loadDone}, 32'h1);
    check("R8", "loadData b2b first", loadData, refMem[20]);
    check("R8", "loadRdIdx b2b first", {27'h0, loadRdIdx}, 32'd7);
    @(negedge clk);
    issueValid = 1'b0;
    #1;
    check("R8", "loadDone b2b second", {31'h0, loadDone}, 32'h1);
    check("R8", "loadData b2b second", loadData, refMem[21]);
    check("R8", "loadRdIdx b2b second", {27'h0, loadRdIdx}, 32'd8);
    @(negedge clk); #1;
    check("R8", "loadDone pulse ends", {31'h0, loadDone}, 32'h0);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [5:0] op;
      logic [31:0] ea;
      int sel;
      sel = $urandom % 10;
      op = (sel < 4) ? LW : (sel < 6) ? SW : (sel < 9) ? SB : 6'($urandom % 64);
      ea = $urandom % 1024;
      if ((op == LW || op == SW) && ($urandom % 8 != 0)) ea[1:0] = 2'b00;
      doOp(op, ea, 16'($urandom), $urandom, 5'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule